// File: doc/BRIEF.md
# Timing-Step Pattern-Match Control Decoder

This block is the control unit of a small 8-bit processor. It holds the current opcode in an instruction register and keeps a one-hot timing step that runs from step 0 up to at most step 7. In every cycle, a table of match rows is compared against the opcode and the step. Each row has a value, a mask of the opcode bits it cares about and a set of steps in which it may fire. The outputs of all rows that match are ORed together into a wide horizontal control word, and each bit of that word drives one control point of the datapath.

Because opcode bits can be left as don't-care, a single row can serve a whole family of opcodes. For example, one row issues the operand-byte load for every immediate-mode opcode. A row may also carry a finish flag. The next cycle then returns to step 0, where the next opcode is fetched, so instructions have different lengths. An instruction that never finishes wraps from step 7 back to step 0. The datapath, the ALU and the memory are outside this block.

Top module: `pla_timing_decoder`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is `step_o` = 8'b0000_0001 and `ctl_o` = 0. The first cycle after reset that has `fetch_i` low shows step 0 with the fetch control word.
- R2: In step 0, the control word is the fetch word: bit 0 (fetch) and bit 1 (program-counter increment). A cycle in step 0 with `fetch_i` low stays in step 0.
- R3: In step 0 with `fetch_i` high, `opcode_i` is captured and the next cycle is step 1.
- R4: In steps 1 to 7, `fetch_i` and `opcode_i` have no effect on the step sequence or on the control word.
- R5: `step_o` is always one-hot (bit n means step n). An unfinished step below 7 moves to the next step in the following cycle.
- R6: After a step whose matching rows carry the finish flag, the next cycle is step 0.
- R7: If no row finishes by step 7, the cycle after step 7 is step 0.
- R8: Control bits are: 0 fetch, 1 PC increment, 2 operand-byte load, 3 ALU add, 4 ALU logic, 5 accumulator write, 6 address-low load, 7 address-high load, 8 memory read, 9 memory write, 10 index write. `ctl_o` is the OR of every row that matches the held opcode and the current step.
- R9: Opcodes with bits[1:0]=00 (implied) give {ALU logic, acc write} in step 1 and finish there.
- R10: Every opcode with bits[1:0]=01 (immediate) shares one row giving {operand load, PC increment} in step 1. Step 2 gives acc write plus ALU add if bit 7 is 0, or ALU logic if bit 7 is 1, and the instruction finishes there.
- R11: Opcodes with bits[1:0]=10 (absolute) give {addr low, PC inc} in step 1 and {addr high, PC inc} in step 2. If bit 7 is 1, step 3 is memory write and the instruction finishes. If bit 7 is 0, step 3 is memory read and step 4 is acc write, and the instruction finishes at step 4.
- R12: Opcodes with bits[1:0]=11 give index write in steps 1 to 7 and never finish, so they take the full eight-step cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_i | input | 1 | Opcode load strobe, used only in step 0 |
| opcode_i | input | 8 | Fetched opcode byte |
| step_o | output | 8 | One-hot timing step |
| ctl_o | output | 11 | Horizontal control word |

## Verification
The hardest state to reach is the step-7 wrap. Only opcodes that no row ever finishes can reach it, so the sweep covers all 256 opcodes, including the whole bits[1:0]=11 family. During every non-zero step, the stimulus toggles `fetch_i` and drives the inverted opcode, so that any reload of the instruction register would show up in the control sequence. A reset in the middle of an absolute load checks that an unfinished instruction is abandoned cleanly.

// File: rtl/pla_dec_pkg.sv
package pla_dec_pkg;
  localparam int OPC_W   = 8;
  localparam int CTL_W   = 11;
  localparam int N_STEPS = 8;
  localparam int N_ROWS  = 11;

  localparam int C_FETCH  = 0;
  localparam int C_PCINC  = 1;
  localparam int C_OPLD   = 2;
  localparam int C_ADD    = 3;
  localparam int C_LOGIC  = 4;
  localparam int C_ACCWR  = 5;
  localparam int C_ADRLO  = 6;
  localparam int C_ADRHI  = 7;
  localparam int C_MEMRD  = 8;
  localparam int C_MEMWR  = 9;
  localparam int C_IDXWR  = 10;

  typedef struct packed {
    logic [OPC_W-1:0]   care;
    logic [OPC_W-1:0]   val;
    logic [N_STEPS-1:0] steps;
    logic [CTL_W-1:0]   ctl;
    logic               fin;
  } row_t;

  function automatic logic [CTL_W-1:0] cb(input int b);
    logic [CTL_W-1:0] v;
    v    = '0;
    v[b] = 1'b1;
    return v;
  endfunction

  function automatic row_t mk(input logic [7:0] care, input logic [7:0] val,
                              input logic [7:0] steps, input logic [CTL_W-1:0] ctl,
                              input logic fin);
    row_t r;
    r.care  = OPC_W'(care);
    r.val   = OPC_W'(val);
    r.steps = N_STEPS'(steps);
    r.ctl   = ctl;
    r.fin   = fin;
    return r;
  endfunction

  // Match table: mode in opcode bits [1:0], variant in bit 7.
  function automatic row_t row_at(input int idx);
    case (idx)
      0:  return mk(8'h00, 8'h00, 8'h01, cb(C_FETCH) | cb(C_PCINC), 1'b0);
      1:  return mk(8'h03, 8'h00, 8'h02, cb(C_LOGIC) | cb(C_ACCWR), 1'b1);
      2:  return mk(8'h03, 8'h01, 8'h02, cb(C_OPLD)  | cb(C_PCINC), 1'b0);
      3:  return mk(8'h83, 8'h01, 8'h04, cb(C_ADD)   | cb(C_ACCWR), 1'b1);
      4:  return mk(8'h83, 8'h81, 8'h04, cb(C_LOGIC) | cb(C_ACCWR), 1'b1);
      5:  return mk(8'h03, 8'h02, 8'h02, cb(C_ADRLO) | cb(C_PCINC), 1'b0);
      6:  return mk(8'h03, 8'h02, 8'h04, cb(C_ADRHI) | cb(C_PCINC), 1'b0);
      7:  return mk(8'h83, 8'h02, 8'h08, cb(C_MEMRD), 1'b0);
      8:  return mk(8'h83, 8'h02, 8'h10, cb(C_ACCWR), 1'b1);
      9:  return mk(8'h83, 8'h82, 8'h08, cb(C_MEMWR), 1'b1);
      10: return mk(8'h03, 8'h03, 8'hFE, cb(C_IDXWR), 1'b0);
      default: return mk(8'hFF, 8'hFF, 8'h00, '0, 1'b0);
    endcase
  endfunction
endpackage

// File: rtl/pla_match_array.sv
module pla_match_array
  import pla_dec_pkg::*;
#(
  parameter int ROWS = N_ROWS
) (
  input  logic [OPC_W-1:0]   ir,
  input  logic [N_STEPS-1:0] step,
  output logic [CTL_W-1:0]   ctl,
  output logic               fin
);
  logic [ROWS-1:0]  hit;
  logic [ROWS-1:0]  fin_v;
  logic [CTL_W-1:0] term [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    localparam row_t RW = row_at(r);
    assign hit[r]   = ((ir & RW.care) == (RW.val & RW.care)) && (|(step & RW.steps));
    assign term[r]  = hit[r] ? RW.ctl : '0;
    assign fin_v[r] = hit[r] & RW.fin;
  end

  always_comb begin
    ctl = '0;
    for (int r = 0; r < ROWS; r++) ctl = ctl | term[r];
  end

  assign fin = |fin_v;
endmodule

// File: rtl/pla_step_seq.sv
module pla_step_seq
  import pla_dec_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               fetch_i,
  input  logic [OPC_W-1:0]   opcode_i,
  input  logic               fin_q,
  output logic [OPC_W-1:0]   ir_d,
  output logic [N_STEPS-1:0] step_d,
  output logic [N_STEPS-1:0] step_q
);
  localparam logic [N_STEPS-1:0] STEP0 = N_STEPS'(1);
  localparam logic [N_STEPS-1:0] STEP1 = N_STEPS'(2);

  logic [OPC_W-1:0] ir_q;

  always_comb begin
    ir_d   = ir_q;
    step_d = step_q;
    if (step_q[0]) begin
      if (fetch_i) begin
        ir_d   = opcode_i;
        step_d = STEP1;
      end
    end else if (fin_q || step_q[N_STEPS-1]) begin
      step_d = STEP0;
    end else begin
      step_d = step_q << 1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q   <= '0;
      step_q <= STEP0;
    end else begin
      ir_q   <= ir_d;
      step_q <= step_d;
    end
  end
endmodule

// File: rtl/pla_timing_decoder.sv
module pla_timing_decoder
  import pla_dec_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               fetch_i,
  input  logic [OPC_W-1:0]   opcode_i,
  output logic [N_STEPS-1:0] step_o,
  output logic [CTL_W-1:0]   ctl_o
);
  logic [OPC_W-1:0]   ir_d;
  logic [N_STEPS-1:0] step_d;
  logic [N_STEPS-1:0] step_q;
  logic [CTL_W-1:0]   ctl_n;
  logic [CTL_W-1:0]   ctl_q;
  logic               fin_n;
  logic               fin_q;

  pla_step_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .fetch_i  (fetch_i),
    .opcode_i (opcode_i),
    .fin_q    (fin_q),
    .ir_d     (ir_d),
    .step_d   (step_d),
    .step_q   (step_q)
  );

  // Decode the state being entered so the registered word lines up with step_o.
  pla_match_array #(.ROWS(N_ROWS)) u_array (
    .ir   (ir_d),
    .step (step_d),
    .ctl  (ctl_n),
    .fin  (fin_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      fin_q <= 1'b0;
    end else begin
      ctl_q <= ctl_n;
      fin_q <= fin_n;
    end
  end

  assign step_o = step_q;
  assign ctl_o  = ctl_q;
endmodule

// File: rtl/pla_timing_decoder_chk.sv
module pla_timing_decoder_chk
  import pla_dec_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               fetch_i,
  input logic [N_STEPS-1:0] step_o,
  input logic [CTL_W-1:0]   ctl_o
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (step_o == N_STEPS'(1)) && (ctl_o == '0));

  a_r5_one_hot: assert property (@(posedge clk) disable iff (rst)
    $countones(step_o) == 1);

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (step_o[0] && !fetch_i) |=> step_o[0]);

  a_r3_load_step1: assert property (@(posedge clk) disable iff (rst)
    (step_o[0] && fetch_i) |=> step_o[1]);

  a_r7_wrap: assert property (@(posedge clk) disable iff (rst)
    step_o[N_STEPS-1] |=> step_o[0]);

  a_r5_advance: assert property (@(posedge clk) disable iff (rst)
    (!step_o[0] && !step_o[N_STEPS-1]) |=>
      (step_o[0] || (step_o == ($past(step_o) << 1))));

  a_r8_fetch_bit_step0: assert property (@(posedge clk) disable iff (rst)
    ctl_o[C_FETCH] |-> step_o[0]);
endmodule

bind pla_timing_decoder pla_timing_decoder_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .fetch_i (fetch_i),
  .step_o  (step_o),
  .ctl_o   (ctl_o)
);

// File: tb/test_pla_timing_decoder.sv
`timescale 1ns/1ps
module test_pla_timing_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_i = 1'b0;
  logic [7:0]  opcode_i = 8'h00;
  logic [7:0]  step_o;
  logic [10:0] ctl_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  pla_timing_decoder i_pla_timing_decoder (
    .clk(clk), .rst(rst), .fetch_i(fetch_i), .opcode_i(opcode_i),
    .step_o(step_o), .ctl_o(ctl_o)
  );

  localparam logic [10:0] W_FETCH = 11'h003;

  function automatic logic [10:0] bit_of(input int b);
    return 11'(1) << b;
  endfunction

  // Expected word from R2, R8-R12.
  function automatic logic [10:0] exp_ctl(input logic [7:0] op, input int s);
    logic [1:0] m = op[1:0];
    logic       v = op[7];
    if (s == 0) return W_FETCH;
    case (m)
      2'b00: return (s == 1) ? (bit_of(4) | bit_of(5)) : 11'h0;
      2'b01: begin
        if (s == 1) return bit_of(2) | bit_of(1);
        if (s == 2) return bit_of(5) | (v ? bit_of(4) : bit_of(3));
        return 11'h0;
      end
      2'b10: begin
        if (s == 1) return bit_of(6) | bit_of(1);
        if (s == 2) return bit_of(7) | bit_of(1);
        if (s == 3) return v ? bit_of(9) : bit_of(8);
        if (s == 4 && !v) return bit_of(5);
        return 11'h0;
      end
      default: return bit_of(10);
    endcase
  endfunction

  function automatic bit exp_fin(input logic [7:0] op, input int s);
    case (op[1:0])
      2'b00: return s == 1;
      2'b01: return s == 2;
      2'b10: return op[7] ? (s == 3) : (s == 4);
      default: return 1'b0;
    endcase
  endfunction

  function automatic string cls_tag(input logic [7:0] op);
    case (op[1:0])
      2'b00: return "R9";
      2'b01: return "R10";
      2'b10: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  // Starts at a negedge in step 0; ends at a negedge back in step 0.
  task automatic run_instr(input logic [7:0] op);
    int  s = 1;
    bit  wrapped = 1'b0;
    opcode_i = op;
    fetch_i  = 1'b1;
    @(negedge clk);
    forever begin
      int nxt;
      check(step_o == (8'(1) << s), "R5 R3 R4 step", 32'(step_o), 32'(8'(1) << s));
      check(ctl_o == exp_ctl(op, s), {cls_tag(op), " R8 R4 ctl"}, 32'(ctl_o), 32'(exp_ctl(op, s)));
      opcode_i = ~op;
      fetch_i  = s[0];
      if (exp_fin(op, s)) nxt = 0;
      else if (s == 7) begin nxt = 0; wrapped = 1'b1; end
      else nxt = s + 1;
      @(negedge clk);
      if (nxt == 0) break;
      s = nxt;
    end
    fetch_i = 1'b0;
    check(step_o == 8'h01 && ctl_o == W_FETCH, wrapped ? "R7 return" : "R6 return",
          {13'h0, ctl_o, step_o}, {13'h0, W_FETCH, 8'h01});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(step_o == 8'h01 && ctl_o == 11'h0, "R1 reset", {13'h0, ctl_o, step_o}, 32'h1);
    rst = 1'b0;
    @(negedge clk);
    check(step_o == 8'h01 && ctl_o == W_FETCH, "R1 after reset",
          {13'h0, ctl_o, step_o}, {13'h0, W_FETCH, 8'h01});
    repeat (3) begin
      opcode_i = 8'h82;
      @(negedge clk);
      check(step_o == 8'h01 && ctl_o == W_FETCH, "R2 idle",
            {13'h0, ctl_o, step_o}, {13'h0, W_FETCH, 8'h01});
    end

    for (int op = 0; op < 256; op++) run_instr(8'(op));

    // Shared immediate row: two distinct opcodes, same step-1 word (R10).
    for (int k = 0; k < 2; k++) begin
      opcode_i = (k == 0) ? 8'h05 : 8'hF9;
      fetch_i  = 1'b1;
      @(negedge clk);
      fetch_i = 1'b0;
      check(ctl_o == (bit_of(2) | bit_of(1)), "R10 shared row", 32'(ctl_o),
            32'(bit_of(2) | bit_of(1)));
      repeat (2) @(negedge clk);
    end

    // Reset during an absolute load (R1).
    opcode_i = 8'h02;
    fetch_i  = 1'b1;
    @(negedge clk);
    fetch_i = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(step_o == 8'h01 && ctl_o == 11'h0, "R1 mid reset", {13'h0, ctl_o, step_o}, 32'h1);
    rst = 1'b0;
    @(negedge clk);
    check(step_o == 8'h01 && ctl_o == W_FETCH, "R1 resume",
          {13'h0, ctl_o, step_o}, {13'h0, W_FETCH, 8'h01});

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule